// File: doc/BRIEF.md
# ROM Bus Gate with Space Check and Wait States

This block sits between a system bus and a read-only word array. Each bus cycle opens when the master drives the active-low strobe low. The block decides in that first clock whether it claims the cycle. Two kinds of hit are possible. The first is an array hit: the upper address bits match a programmable base, and the cycle's 3-bit function code passes a 2-bit space-restriction field. The second is a register hit on a small control block at a fixed address. Only supervisor data cycles may reach that control block.

When the block claims a cycle, it counts a programmable number of clocks and then pulses an active-low acknowledge for one clock. On reads it drives data while the transfer is in progress. When it does not claim a cycle, it stays silent: it gives no acknowledge and drives no data, so that another decoder on the bus may answer.

Three control words hold the configuration:
- a control word with a lock bit, the space field and the wait field;
- the upper part of the array base;
- the lower part of the array base.

Reset loads build-time defaults into these words. Setting the lock bit freezes the wait field and the base. A stop input also freezes the base for as long as it is high.

Top module: `romif_ctl`

## Requirements
- R1: After reset, ack_n is 1 and rdata_oe is 0. The control word reads RST_SPACE in bits [5:4], RST_WAIT in bits [1:0] and lock 0. The base registers read RST_BASE; with the defaults, high reads 0x0001 and low reads 0x0000.
- R2: Space field 00 permits function codes whose low two bits are 01 or 10. Space 01 permits only low bits 10. Space 10 permits only 101 and 110. Space 11 permits only 110. The rule applies to array accesses.
- R3: An array access whose function code is not permitted gets no acknowledge, and rdata_oe stays 0 for the whole strobe.
- R4: Let N be the clocks per transfer, where wait code 00 gives 3, 01 gives 4, 10 gives 5 and 11 gives 2. ack_n is low in the N-th clock counted from the clock in which strobe was first low. This holds for both array and register accesses.
- R5: ack_n stays low for exactly one clock. No new access is accepted while strobe stays low after the acknowledge.
- R6: An array hit is bus_addr[ADDR_W-1:ARR_AW] equal to the base. The read data is ROM_SEED ^ w ^ (w << 5), truncated to 16 bits, where w = bus_addr[ARR_AW-1:1].
- R7: The registers sit at CTRL_ADDR, CTRL_ADDR+2 and CTRL_ADDR+4, and CTRL_ADDR+6 reads 0.
  - The control word has lock in bit 15, space in [5:4] and wait in [1:0].
  - The high register holds base bits [ADDR_W-1:16] in its low bits.
  - The low register holds base bits [15:ARR_AW] in the same positions.
  - All other bits read 0.
  - The registers are claimed only with function code 101, and a register hit takes priority over the array.
- R8: The wait field changes on a write only while lock is 0. Lock can be set by writing 1 but cannot be cleared except by reset.
- R9: Writes to either base register are ignored while lock is 1 or stop_req is 1.
- R10: rdata_oe is 1 only during claimed reads, and it is 1 in the clock in which ack_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| bus_addr | input | ADDR_W | Byte address of the cycle |
| bus_fc | input | 3 | Function code of the cycle |
| bus_rw | input | 1 | 1 for read, 0 for write |
| bus_strb_n | input | 1 | Active-low cycle strobe |
| bus_wdata | input | 16 | Write data |
| stop_req | input | 1 | Stop condition that freezes the base |
| bus_rdata | output | 16 | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | Read data drive enable |
| bus_ack_n | output | 1 | Active-low transfer acknowledge |

## Verification
The hardest cases to reach are the rejected accesses for the restrictive space codes. To reach them, the bench first writes each space code through the control word, which is itself a timed register cycle. It then sweeps all eight function codes against the array. For each rejected code it watches the whole strobe window to confirm that neither an acknowledge nor a data drive appears.

The lock case needs a particular ordering. One write sets the lock and changes the wait code in the same cycle, and a later write attempts to change the wait code again. This shows that the lock is applied to later writes and not to the write that sets it.

// File: rtl/romif_ctl.sv
module romif_ctl #(
  parameter int ADDR_W = 24,
  parameter int ARR_AW = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFFF820,
  parameter logic [ADDR_W-1:0] RST_BASE  = 24'h010000,
  parameter logic [1:0] RST_SPACE = 2'b00,
  parameter logic [1:0] RST_WAIT  = 2'b00,
  parameter logic [15:0] ROM_SEED = 16'hC3A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_fc,
  input  logic              bus_rw,
  input  logic              bus_strb_n,
  input  logic [15:0]       bus_wdata,
  input  logic              stop_req,
  output logic [15:0]       bus_rdata,
  output logic              bus_rdata_oe,
  output logic              bus_ack_n
);
  localparam int HI_W = ADDR_W - 16;

  typedef enum logic [1:0] {S_IDLE, S_CNT, S_ACK, S_HOLD} st_t;
  st_t st;

  logic [2:0]  cnt;
  logic        lock_q;
  logic [1:0]  space_q, wait_q;
  logic [ADDR_W-1:ARR_AW] base_q;
  logic        rd_q, sel_reg_q;
  logic [1:0]  idx_q;
  logic [15:0] wdata_q, rdata_q;

  logic fc_ok, reg_hit, reg_ok, arr_ok, do_wr;
  logic [15:0] widx, rom_word, reg_val;
  logic unused_bits;

  always_comb begin
    unique case (space_q)
      2'b00: fc_ok = (bus_fc[1:0] == 2'b01) || (bus_fc[1:0] == 2'b10);
      2'b01: fc_ok = (bus_fc[1:0] == 2'b10);
      2'b10: fc_ok = (bus_fc == 3'b101) || (bus_fc == 3'b110);
      2'b11: fc_ok = (bus_fc == 3'b110);
    endcase
  end

  assign reg_hit = bus_addr[ADDR_W-1:3] == CTRL_ADDR[ADDR_W-1:3];
  assign reg_ok  = reg_hit && (bus_fc == 3'b101);
  assign arr_ok  = !reg_hit && (bus_addr[ADDR_W-1:ARR_AW] == base_q) && fc_ok;

  assign widx     = 16'(bus_addr[ARR_AW-1:1]);
  assign rom_word = ROM_SEED ^ widx ^ (widx << 5);

  always_comb begin
    unique case (bus_addr[2:1])
      2'd0: reg_val = {lock_q, 9'b0, space_q, 2'b0, wait_q};
      2'd1: reg_val = 16'(base_q[ADDR_W-1:16]);
      2'd2: reg_val = {base_q[15:ARR_AW], {ARR_AW{1'b0}}};
      2'd3: reg_val = 16'h0000;
    endcase
  end

  assign do_wr = (st == S_CNT) && !bus_strb_n && (cnt == 3'd1) && !rd_q && sel_reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= 3'd0;
      rd_q      <= 1'b0;
      sel_reg_q <= 1'b0;
      idx_q     <= 2'd0;
      wdata_q   <= 16'h0000;
      rdata_q   <= 16'h0000;
    end else begin
      unique case (st)
        S_IDLE: if (!bus_strb_n) begin
          if (reg_ok || arr_ok) begin
            st        <= S_CNT;
            cnt       <= (wait_q == 2'b11) ? 3'd1 : 3'(wait_q) + 3'd2;
            rd_q      <= bus_rw;
            sel_reg_q <= reg_ok;
            idx_q     <= bus_addr[2:1];
            wdata_q   <= bus_wdata;
            rdata_q   <= reg_ok ? reg_val : rom_word;
          end else begin
            st <= S_HOLD;
          end
        end
        S_CNT: begin
          if (bus_strb_n)          st <= S_IDLE;
          else if (cnt == 3'd1)    st <= S_ACK;
          else                     cnt <= cnt - 3'd1;
        end
        S_ACK:  st <= bus_strb_n ? S_IDLE : S_HOLD;
        S_HOLD: if (bus_strb_n) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      space_q <= RST_SPACE;
      wait_q  <= RST_WAIT;
      base_q  <= RST_BASE[ADDR_W-1:ARR_AW];
    end else if (do_wr) begin
      unique case (idx_q)
        2'd0: begin
          lock_q  <= lock_q | wdata_q[15];
          space_q <= wdata_q[5:4];
          if (!lock_q) wait_q <= wdata_q[1:0];
        end
        2'd1: if (!lock_q && !stop_req) base_q[ADDR_W-1:16] <= wdata_q[HI_W-1:0];
        2'd2: if (!lock_q && !stop_req) base_q[15:ARR_AW] <= wdata_q[15:ARR_AW];
        2'd3: ;
      endcase
    end
  end

  assign bus_ack_n    = (st != S_ACK);
  assign bus_rdata_oe = rd_q && ((st == S_CNT) || (st == S_ACK));
  assign bus_rdata    = bus_rdata_oe ? rdata_q : 16'h0000;
  assign unused_bits  = ^{bus_addr[0], wdata_q};
endmodule

module romif_ctl_chk #(
  parameter int BASE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fc_super,
  input logic              bus_rw,
  input logic              bus_ack_n,
  input logic              bus_rdata_oe,
  input logic              stop_req,
  input logic              lock_q,
  input logic [1:0]        wait_q,
  input logic              space_hi,
  input logic [BASE_W-1:0] base_q
);
  a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |=> bus_ack_n);
  a_r10_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> bus_rw);
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r8_wait_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(wait_q));
  a_r9_base_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q || stop_req) |=> $stable(base_q));
  a_r2_super_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ack_n && space_hi) |-> fc_super);
endmodule

bind romif_ctl romif_ctl_chk #(.BASE_W(ADDR_W - ARR_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_super(bus_fc[2]), .bus_rw(bus_rw),
  .bus_ack_n(bus_ack_n), .bus_rdata_oe(bus_rdata_oe), .stop_req(stop_req),
  .lock_q(lock_q), .wait_q(wait_q), .space_hi(space_q[1]), .base_q(base_q)
);

// File: tb/romif_ctl_tb.sv
module romif_ctl_tb;
  localparam logic [23:0] CTRL = 24'hFFF820;
  localparam logic [15:0] SEED = 16'hC3A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  fc = '0;
  logic        rw = 1'b1;
  logic        strb_n = 1'b1;
  logic [15:0] wd = '0;
  logic        stop = 1'b0;
  logic [15:0] rdata;
  logic        oe, ack_n;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  romif_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_fc(fc), .bus_rw(rw),
    .bus_strb_n(strb_n), .bus_wdata(wd), .stop_req(stop),
    .bus_rdata(rdata), .bus_rdata_oe(oe), .bus_ack_n(ack_n)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_rom(input logic [23:0] a);
    logic [15:0] w;
    w = 16'(a[11:1]);
    return SEED ^ w ^ (w << 5);
  endfunction

  function automatic int exp_clks(input logic [1:0] w);
    return (w == 2'b11) ? 2 : 3 + int'(w);
  endfunction

  function automatic bit fc_allowed(input logic [1:0] s, input logic [2:0] f);
    case (s)
      2'b00: return f[1:0] == 2'b01 || f[1:0] == 2'b10;
      2'b01: return f[1:0] == 2'b10;
      2'b10: return f == 3'b101 || f == 3'b110;
      default: return f == 3'b110;
    endcase
  endfunction

  task automatic bus_op(input logic [23:0] a, input logic [2:0] f, input logic r,
                        input logic [15:0] d, output bit acked, output int lat,
                        output logic [15:0] rd, output bit seen_oe, output bit extra_ack);
    @(negedge clk);
    addr = a; fc = f; rw = r; wd = d; strb_n = 1'b0;
    acked = 0; lat = 0; rd = '0; seen_oe = 0; extra_ack = 0;
    for (int k = 1; k <= 8 && !acked; k++) begin
      @(negedge clk);
      if (oe) seen_oe = 1;
      if (!ack_n) begin
        acked = 1; lat = k; rd = rdata;
      end
    end
    if (acked) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (!ack_n) extra_ack = 1;
      end
    end
    strb_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic reg_wr(input int idx, input logic [15:0] d, input string tag);
    bit a, o, x; int l; logic [15:0] r;
    bus_op(CTRL + 24'(idx * 2), 3'b101, 1'b0, d, a, l, r, o, x);
    chk({tag, " write acked"}, 32'(a), 32'd1);
    chk("R10 no drive on write", 32'(o), 32'd0);
  endtask

  task automatic reg_rd(input int idx, output logic [15:0] d, output int lat);
    bit a, o, x;
    bus_op(CTRL + 24'(idx * 2), 3'b101, 1'b1, 16'h0, a, lat, d, o, x);
    chk("R7 register read acked", 32'(a), 32'd1);
  endtask

  task automatic t_reset;
    logic [15:0] d; int l;
    chk("R1 ack_n idle after reset", 32'(ack_n), 32'd1);
    chk("R1 rdata_oe idle after reset", 32'(oe), 32'd0);
    reg_rd(0, d, l);
    chk("R1 control default", 32'(d), 32'h0000);
    chk("R4 register latency code 00", 32'(l), 32'd3);
    reg_rd(1, d, l);
    chk("R1 base high default", 32'(d), 32'h0001);
    reg_rd(2, d, l);
    chk("R1 base low default", 32'(d), 32'h0000);
    reg_rd(3, d, l);
    chk("R7 unused slot reads zero", 32'(d), 32'h0000);
  endtask

  task automatic t_wait;
    bit a, o, x; int l; logic [15:0] r, d; logic [23:0] ad;
    for (int w = 0; w < 4; w++) begin
      reg_wr(0, 16'(w), "R4");
      ad = 24'h010020 + 24'(w * 6);
      bus_op(ad, 3'b101, 1'b1, 16'h0, a, l, r, o, x);
      chk("R4 array latency", 32'(l), 32'(exp_clks(2'(w))));
      chk("R6 array data", 32'(r), 32'(exp_rom(ad)));
      chk("R10 drive during read", 32'(o), 32'd1);
      chk("R5 single acknowledge", 32'(x), 32'd0);
      reg_rd(0, d, l);
      chk("R4 register latency", 32'(l), 32'(exp_clks(2'(w))));
    end
    reg_wr(0, 16'h0000, "R4");
  endtask

  task automatic t_space;
    bit a, o, x, ok; int l; logic [15:0] r;
    for (int s = 0; s < 4; s++) begin
      reg_wr(0, 16'(s << 4), "R2");
      for (int f = 0; f < 8; f++) begin
        ok = fc_allowed(2'(s), 3'(f));
        bus_op(24'h010100, 3'(f), 1'b1, 16'h0, a, l, r, o, x);
        chk($sformatf("R2 claim space %0d fc %0d", s, f), 32'(a), 32'(ok));
        if (!ok) chk($sformatf("R3 silent space %0d fc %0d", s, f), 32'(o), 32'd0);
      end
    end
    reg_wr(0, 16'h0000, "R2");
  endtask

  task automatic t_regs;
    bit a, o, x; int l; logic [15:0] r, d;
    reg_wr(1, 16'h0012, "R7");
    reg_wr(2, 16'hFFFF, "R7");
    reg_rd(1, d, l);
    chk("R7 base high readback", 32'(d), 32'h0012);
    reg_rd(2, d, l);
    chk("R7 base low reserved bits", 32'(d), 32'hF000);
    bus_op(24'h12F004, 3'b101, 1'b1, 16'h0, a, l, r, o, x);
    chk("R6 hit at new base", 32'(a), 32'd1);
    chk("R6 data at new base", 32'(r), 32'(exp_rom(24'h12F004)));
    bus_op(24'h010004, 3'b101, 1'b1, 16'h0, a, l, r, o, x);
    chk("R6 old base missed", 32'(a), 32'd0);
    bus_op(CTRL, 3'b001, 1'b1, 16'h0, a, l, r, o, x);
    chk("R7 register refuses fc 001", 32'(a), 32'd0);
    bus_op(CTRL, 3'b110, 1'b1, 16'h0, a, l, r, o, x);
    chk("R7 register refuses fc 110", 32'(a), 32'd0);
    reg_wr(0, 16'h7FCE, "R7");
    reg_rd(0, d, l);
    chk("R7 control reserved bits", 32'(d), 32'h0002);
    reg_wr(0, 16'h0000, "R7");
  endtask

  task automatic t_stop;
    logic [15:0] d; int l;
    stop = 1'b1;
    reg_wr(1, 16'h0034, "R9");
    reg_rd(1, d, l);
    chk("R9 base high frozen by stop", 32'(d), 32'h0012);
    reg_wr(2, 16'h0000, "R9");
    reg_rd(2, d, l);
    chk("R9 base low frozen by stop", 32'(d), 32'hF000);
    reg_wr(0, 16'h0003, "R8");
    reg_rd(0, d, l);
    chk("R8 wait writable while unlocked", 32'(d), 32'h0003);
    stop = 1'b0;
    reg_wr(0, 16'h0000, "R8");
  endtask

  task automatic t_lock;
    logic [15:0] d; int l;
    reg_wr(0, 16'h8001, "R8");
    reg_rd(0, d, l);
    chk("R8 lock and wait set together", 32'(d), 32'h8001);
    chk("R4 register latency code 01", 32'(l), 32'd4);
    reg_wr(0, 16'h0012, "R8");
    reg_rd(0, d, l);
    chk("R8 wait frozen, lock sticky, space updated", 32'(d), 32'h8011);
    reg_wr(1, 16'h0056, "R9");
    reg_rd(1, d, l);
    chk("R9 base frozen by lock", 32'(d), 32'h0012);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wait();
    t_space();
    t_regs();
    t_stop();
    t_lock();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule